// File: doc/BRIEF.md
# Atomic-Group Coalescing Store Buffer

This block sits between a core's retired stores and its private cache. Stores arrive one line address at a time, each with a byte mask. A store whose line is already held by the group being built merges into that slot. This holds even when other stores came between the two, so several writes to one line cost a single cache write. Because such merging reorders stores, the lines of a group are never made visible one by one. The whole group is handed to the cache in a single cycle, and only after write permission for every line in it is held.

Permission is gathered one line at a time. Lines are taken in ascending order of a configurable address key field, with the lower slot winning a tie. A line that is not yet granted is simply asked for again, and the permissions already won are kept. Every core follows the same global order, so no circular wait can form. A group is also capped per cache set: it may never hold more lines of one set than the set has ways, so it always fits in the set-associative structures on the write path.

The buffer holds at most two groups. One is draining (gathering permission). The other is open (still accepting stores). An open group is closed by a fence, by a store it cannot take, or by both happening at once. If the draining group has not committed yet, the closed group waits with the store port blocked. It starts requesting permission in the cycle after that commit.

Top module: `gsb_top`

## Requirements
- R1: After reset no permission request and no commit are raised, and the store port reports ready.
- R2: A store to a line already in the open group merges into that slot. Its enabled bytes overwrite the old ones, the other bytes are kept, and no extra slot is used.
- R3: A store to a new line whose set (line bits SET_LSB upward, SET_W wide) already holds WAYS lines of the open group is refused and closes the group. Retrying that store afterwards puts it into a fresh group.
- R4: A store to a new line when no slot is free is refused and closes a non-empty open group. A merging store is still taken while all slots are in use.
- R5: A fence closes a non-empty open group, and a store offered in the same cycle as a fence is refused.
- R6: Permission is requested for one line of the draining group at a time, in ascending order of line bits KEY_LSB upward (KEY_W wide). The lowest slot index wins a tie.
- R7: While the grant input is low, the request stays raised on the same line. A line already granted is not requested again.
- R8: The commit output is raised for exactly one cycle, in the cycle right after the last grant of the group. It marks exactly the group's slots, and those slots are free from the next cycle on.
- R9: A group that closes while another group is still draining blocks the store port until that commit. It then requests its lowest-key line in the following cycle.
- R10: Every accepted byte appears, with its most recent value, in exactly one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store would be taken this cycle |
| st_line | input | LINE_AW | Line address of the store |
| st_bmask | input | LINE_BYTES | Byte enables within the line |
| st_data | input | 8*LINE_BYTES | Store data, byte lane b in bits 8b+7..8b |
| fence_req | input | 1 | Close the open group |
| perm_req | output | 1 | Write permission wanted for perm_line |
| perm_line | output | LINE_AW | Line currently requested |
| perm_gnt | input | 1 | Permission for perm_line granted this cycle |
| commit_valid | output | 1 | Whole group written this cycle |
| commit_sel | output | ENTRIES | Slots belonging to the committing group |
| commit_line | output | ENTRIES*LINE_AW | Line address of every slot |
| commit_bmask | output | ENTRIES*LINE_BYTES | Accumulated byte enables of every slot |
| commit_data | output | ENTRIES*8*LINE_BYTES | Merged data of every slot |

## Verification
The assertions assume that the grant input only means something while a request is raised, and that the cache side never withdraws a grant it has given. The request-order property also assumes that grants are only ever given for the line presented on perm_line. The bench respects these limits by driving a grant only in a cycle where it sees a request, and by holding each grant low for a chosen number of cycles. Stimulus sweeps line addresses across all sets, so that set caps, full buffers, merges into an open line and fences paired with stores all occur. Whether a store is taken is predicted from the bench's own model of the open group.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

    localparam int GSB_ENTRIES    = 8;
    localparam int GSB_LINE_AW    = 10;
    localparam int GSB_LINE_BYTES = 4;
    localparam int GSB_SET_W      = 2;
    localparam int GSB_WAYS       = 4;

    // Life cycle of one buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_OPEN  = 2'd1,
        SLOT_DRAIN = 2'd2
    } slot_st_e;

endpackage

// File: rtl/gsb_set_limit.sv
// Per-set line counters for the group that is still accepting stores.
module gsb_set_limit #(
    parameter int SET_W = 2,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [SET_W-1:0] inc_set,
    input  logic [SET_W-1:0] qry_set,
    output logic             qry_full
);
    localparam int SETS  = 1 << SET_W;
    localparam int CNT_W = $clog2(WAYS + 1);

    logic [SETS-1:0] full_vec;

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    cnt <= '0;
                else if (inc && inc_set == SET_W'(s))
                    cnt <= cnt + 1'b1;
            end
            assign full_vec[s] = (cnt >= CNT_W'(WAYS));
        end
    endgenerate

    assign qry_full = full_vec[qry_set];

endmodule

// File: rtl/gsb_key_pick.sv
// Picks the candidate slot with the smallest key; lower index wins ties.
module gsb_key_pick #(
    parameter int N     = 8,
    parameter int KEY_W = 10,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][KEY_W-1:0] keys,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    logic [KEY_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || keys[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = keys[i];
            end
        end
    end

endmodule

// File: rtl/gsb_top.sv
module gsb_top
    import gsb_pkg::*;
#(
    parameter int ENTRIES    = GSB_ENTRIES,
    parameter int LINE_AW    = GSB_LINE_AW,
    parameter int LINE_BYTES = GSB_LINE_BYTES,
    parameter int SET_LSB    = 0,
    parameter int SET_W      = GSB_SET_W,
    parameter int WAYS       = GSB_WAYS,
    parameter int KEY_LSB    = 0,
    parameter int KEY_W      = GSB_LINE_AW
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  st_valid,
    output logic                                  st_ready,
    input  logic [LINE_AW-1:0]                    st_line,
    input  logic [LINE_BYTES-1:0]                 st_bmask,
    input  logic [8*LINE_BYTES-1:0]               st_data,
    input  logic                                  fence_req,
    output logic                                  perm_req,
    output logic [LINE_AW-1:0]                    perm_line,
    input  logic                                  perm_gnt,
    output logic                                  commit_valid,
    output logic [ENTRIES-1:0]                    commit_sel,
    output logic [ENTRIES-1:0][LINE_AW-1:0]       commit_line,
    output logic [ENTRIES-1:0][LINE_BYTES-1:0]    commit_bmask,
    output logic [ENTRIES-1:0][8*LINE_BYTES-1:0]  commit_data
);
    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Slot storage
    slot_st_e               st_q   [ENTRIES];
    logic [ENTRIES-1:0]     own_q;
    logic [LINE_AW-1:0]     line_q [ENTRIES];
    logic [LINE_BYTES-1:0]  bm_q   [ENTRIES];
    logic [DATA_W-1:0]      dat_q  [ENTRIES];
    logic                   close_pend;

    logic [ENTRIES-1:0]            open_vec, drain_vec, free_vec, hit_vec;
    logic [ENTRIES-1:0][KEY_W-1:0] keys;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
            assign open_vec[i]     = (st_q[i] == SLOT_OPEN);
            assign drain_vec[i]    = (st_q[i] == SLOT_DRAIN);
            assign free_vec[i]     = (st_q[i] == SLOT_FREE);
            assign hit_vec[i]      = open_vec[i] && (line_q[i] == st_line);
            assign keys[i]         = line_q[i][KEY_LSB +: KEY_W];
            assign commit_line[i]  = line_q[i];
            assign commit_bmask[i] = bm_q[i];
            assign commit_data[i]  = dat_q[i];
        end
    endgenerate

    // Lowest-index hit and lowest-index free slot
    logic             hit_any, free_any;
    logic [IDX_W-1:0] hit_idx, free_idx;

    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i] && !hit_any) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (free_vec[i] && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Unmasked lanes cleared on allocation
    logic [DATA_W-1:0] st_data_m;
    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++)
            st_data_m[b*8 +: 8] = st_bmask[b] ? st_data[b*8 +: 8] : 8'h00;
    end

    // Group bookkeeping
    logic open_any, drain_any, all_owned;
    logic set_full, new_ok, accept, blocked_new, close_req, do_close, promote;
    logic grant, pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [ENTRIES-1:0] need_vec;

    assign open_any     = |open_vec;
    assign drain_any    = |drain_vec;
    assign need_vec     = drain_vec & ~own_q;
    assign all_owned    = (need_vec == '0);
    assign commit_valid = drain_any && all_owned;
    assign commit_sel   = drain_vec & {ENTRIES{commit_valid}};

    assign new_ok      = free_any && !set_full;
    assign st_ready    = !close_pend && !fence_req && (hit_any || new_ok);
    assign accept      = st_valid && st_ready;
    assign blocked_new = st_valid && !close_pend && !fence_req && !hit_any
                         && !new_ok && open_any;
    assign close_req   = (fence_req && open_any) || blocked_new;
    assign do_close    = close_pend || close_req;
    assign promote     = do_close && (!drain_any || commit_valid);

    gsb_set_limit #(
        .SET_W (SET_W),
        .WAYS  (WAYS)
    ) u_set_limit (
        .clk      (clk),
        .rst      (rst),
        .clr      (promote),
        .inc      (accept && !hit_any),
        .inc_set  (st_line[SET_LSB +: SET_W]),
        .qry_set  (st_line[SET_LSB +: SET_W]),
        .qry_full (set_full)
    );

    gsb_key_pick #(
        .N     (ENTRIES),
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_key_pick (
        .cand  (need_vec),
        .keys  (keys),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign perm_req  = pick_found;
    assign perm_line = line_q[pick_idx];
    assign grant     = perm_req && perm_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            close_pend <= 1'b0;
            own_q      <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]   <= SLOT_FREE;
                line_q[i] <= '0;
                bm_q[i]   <= '0;
                dat_q[i]  <= '0;
            end
        end else begin
            close_pend <= do_close && !promote;
            for (int i = 0; i < ENTRIES; i++) begin
                if (drain_vec[i] && commit_valid)
                    st_q[i] <= SLOT_FREE;
                if (open_vec[i] && promote) begin
                    st_q[i]  <= SLOT_DRAIN;
                    own_q[i] <= 1'b0;
                end
                if (grant && pick_idx == IDX_W'(i))
                    own_q[i] <= 1'b1;
                if (accept && hit_any && hit_idx == IDX_W'(i)) begin
                    bm_q[i] <= bm_q[i] | st_bmask;
                    for (int b = 0; b < LINE_BYTES; b++)
                        if (st_bmask[b])
                            dat_q[i][b*8 +: 8] <= st_data[b*8 +: 8];
                end
                if (accept && !hit_any && free_idx == IDX_W'(i)) begin
                    st_q[i]   <= SLOT_OPEN;
                    own_q[i]  <= 1'b0;
                    line_q[i] <= st_line;
                    bm_q[i]   <= st_bmask;
                    dat_q[i]  <= st_data_m;
                end
            end
        end
    end

endmodule

// File: rtl/gsb_chk.sv
module gsb_chk #(
    parameter int ENTRIES = 8,
    parameter int LINE_AW = 10,
    parameter int SET_LSB = 0,
    parameter int SET_W   = 2,
    parameter int WAYS    = 4,
    parameter int KEY_LSB = 0,
    parameter int KEY_W   = 10
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            st_ready,
    input logic                            perm_req,
    input logic [LINE_AW-1:0]              perm_line,
    input logic                            perm_gnt,
    input logic                            commit_valid,
    input logic [ENTRIES-1:0]              commit_sel,
    input logic [ENTRIES-1:0][LINE_AW-1:0] commit_line,
    input logic [ENTRIES-1:0]              open_vec,
    input logic                            close_pend
);
    localparam int SETS = 1 << SET_W;

    logic [KEY_W-1:0] key_now, last_key;
    logic             have_last;
    int               worst;

    assign key_now = perm_line[KEY_LSB +: KEY_W];

    always_ff @(posedge clk) begin
        if (rst || commit_valid) begin
            have_last <= 1'b0;
            last_key  <= '0;
        end else if (perm_req && perm_gnt) begin
            have_last <= 1'b1;
            last_key  <= key_now;
        end
    end

    always_comb begin
        worst = 0;
        for (int s = 0; s < SETS; s++) begin
            int c;
            c = 0;
            for (int i = 0; i < ENTRIES; i++)
                if (open_vec[i] && commit_line[i][SET_LSB +: SET_W] == SET_W'(s))
                    c++;
            if (c > worst)
                worst = c;
        end
    end

    p_set_cap_r3: assert property (@(posedge clk) disable iff (rst)
        worst <= WAYS);

    p_key_order_r6: assert property (@(posedge clk) disable iff (rst)
        (perm_req && have_last) |-> (key_now >= last_key));

    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        (perm_req && !perm_gnt) |=> (perm_req && $stable(perm_line)));

    p_commit_once_r8: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> !commit_valid);

    p_commit_shape_r8: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (!perm_req && commit_sel != '0));

    p_pend_block_r9: assert property (@(posedge clk) disable iff (rst)
        close_pend |-> !st_ready);

endmodule

bind gsb_top gsb_chk #(
    .ENTRIES (ENTRIES),
    .LINE_AW (LINE_AW),
    .SET_LSB (SET_LSB),
    .SET_W   (SET_W),
    .WAYS    (WAYS),
    .KEY_LSB (KEY_LSB),
    .KEY_W   (KEY_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .st_ready     (st_ready),
    .perm_req     (perm_req),
    .perm_line    (perm_line),
    .perm_gnt     (perm_gnt),
    .commit_valid (commit_valid),
    .commit_sel   (commit_sel),
    .commit_line  (commit_line),
    .open_vec     (open_vec),
    .close_pend   (close_pend)
);

// File: tb/gsb_top_tb.sv
module gsb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int AW = 10;
    localparam int NB = 4;
    localparam int DW = 32;
    localparam int WY = 4;

    logic clk = 1'b0;
    logic rst;
    logic st_valid, st_ready, fence_req, perm_req, perm_gnt, commit_valid;
    logic [AW-1:0] st_line, perm_line;
    logic [NB-1:0] st_bmask;
    logic [DW-1:0] st_data;
    logic [NE-1:0] commit_sel;
    logic [NE-1:0][AW-1:0] commit_line;
    logic [NE-1:0][NB-1:0] commit_bmask;
    logic [NE-1:0][DW-1:0] commit_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    gsb_top u_dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
        .st_bmask(st_bmask), .st_data(st_data), .fence_req(fence_req),
        .perm_req(perm_req), .perm_line(perm_line), .perm_gnt(perm_gnt),
        .commit_valid(commit_valid), .commit_sel(commit_sel),
        .commit_line(commit_line), .commit_bmask(commit_bmask),
        .commit_data(commit_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of up to two groups
    int            m_n   [2];
    logic [AW-1:0] m_line[2][NE];
    logic [NB-1:0] m_bm  [2][NE];
    logic [DW-1:0] m_dat [2][NE];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lanes(input logic [NB-1:0] bm);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++) r[b*8 +: 8] = bm[b] ? 8'hFF : 8'h00;
        return r;
    endfunction

    function automatic bit exp_accept(input int g, input logic [AW-1:0] ln);
        int c = 0;
        for (int j = 0; j < m_n[g]; j++) if (m_line[g][j] == ln) return 1'b1;
        if (m_n[g] >= NE) return 1'b0;
        for (int j = 0; j < m_n[g]; j++) if (m_line[g][j][1:0] == ln[1:0]) c++;
        return c < WY;
    endfunction

    task automatic model_store(input int g, input logic [AW-1:0] ln,
                               input logic [NB-1:0] bm, input logic [DW-1:0] d);
        for (int j = 0; j < m_n[g]; j++) begin
            if (m_line[g][j] == ln) begin
                for (int b = 0; b < NB; b++)
                    if (bm[b]) m_dat[g][j][b*8 +: 8] = d[b*8 +: 8];
                m_bm[g][j] = m_bm[g][j] | bm;
                return;
            end
        end
        m_line[g][m_n[g]] = ln;
        m_bm[g][m_n[g]]   = bm;
        m_dat[g][m_n[g]]  = d & lanes(bm);
        m_n[g]++;
    endtask

    // Offer one store for one cycle; optionally with a fence in the same cycle
    task automatic put(input int g, input logic [AW-1:0] ln, input logic [NB-1:0] bm,
                       input logic [DW-1:0] d, input bit with_fence,
                       input bit exp_acc, input string req);
        bit acc;
        @(negedge clk);
        st_valid = 1'b1; st_line = ln; st_bmask = bm; st_data = d;
        fence_req = with_fence;
        #1 acc = st_ready;
        chk(acc == exp_acc, req, "store accept", acc, exp_acc);
        if (acc) model_store(g, ln, bm, d);
        @(posedge clk);
        #1 st_valid = 1'b0; fence_req = 1'b0;
    endtask

    task automatic fence();
        @(negedge clk);
        fence_req = 1'b1;
        @(posedge clk);
        #1 fence_req = 1'b0;
    endtask

    // Grant the draining group, holding each grant back 'stall' cycles
    task automatic drain(input int g, input int stall);
        logic [AW-1:0] srt[NE];
        logic [AW-1:0] held;
        int k = 0, waitc = 0, cyc = 0, last_g = -10;
        bit holding = 0, done = 0;
        for (int j = 0; j < m_n[g]; j++) srt[j] = m_line[g][j];
        for (int a = 0; a < m_n[g]; a++)
            for (int b = a + 1; b < m_n[g]; b++)
                if (srt[b] < srt[a]) begin
                    logic [AW-1:0] t = srt[a]; srt[a] = srt[b]; srt[b] = t;
                end
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (commit_valid) begin
                int nsel = 0;
                perm_gnt = 1'b0;
                chk(k == m_n[g], "R8", "grants before commit", k, m_n[g]);
                chk(cyc == last_g + 1, "R8", "commit cycle", cyc, last_g + 1);
                for (int i = 0; i < NE; i++) begin
                    if (commit_sel[i]) begin
                        bit found = 0;
                        nsel++;
                        for (int j = 0; j < m_n[g]; j++) begin
                            if (m_line[g][j] == commit_line[i]) begin
                                found = 1;
                                chk(commit_bmask[i] == m_bm[g][j], "R2", "byte mask",
                                    commit_bmask[i], m_bm[g][j]);
                                chk((commit_data[i] & lanes(m_bm[g][j])) == m_dat[g][j],
                                    "R10", "merged data",
                                    commit_data[i] & lanes(m_bm[g][j]), m_dat[g][j]);
                            end
                        end
                        chk(found, "R10", "committed line known", commit_line[i], 0);
                    end
                end
                chk(nsel == m_n[g], "R2", "slots in commit", nsel, m_n[g]);
                done = 1;
            end else if (perm_req) begin
                if (holding)
                    chk(perm_line == held, "R7", "request held", perm_line, held);
                else
                    chk(k < m_n[g] && perm_line == srt[k], "R6", "request order",
                        perm_line, srt[k]);
                if (waitc < stall) begin
                    perm_gnt = 1'b0; waitc++; holding = 1; held = perm_line;
                end else begin
                    perm_gnt = 1'b1; k++; waitc = 0; holding = 0; last_g = cyc;
                end
            end else begin
                perm_gnt = 1'b0;
                chk(1'b0, "R6", "request missing", 0, 1);
            end
        end
        chk(done, "R8", "commit seen", done, 1);
        m_n[g] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        m_n[0] = 0; m_n[1] = 0;
        rst = 1'b1; st_valid = 0; st_line = '0; st_bmask = '0; st_data = '0;
        fence_req = 0; perm_gnt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 idle state
        @(negedge clk);
        chk(!perm_req, "R1", "perm_req after reset", perm_req, 0);
        chk(!commit_valid, "R1", "commit after reset", commit_valid, 0);
        chk(st_ready, "R1", "st_ready after reset", st_ready, 1);

        // R2 merge of non-adjacent stores, R5 fence with store
        put(0, 10'h013, 4'b0001, 32'h000000A1, 0, 1, "R2");
        put(0, 10'h005, 4'b0011, 32'h0000B2B3, 0, 1, "R2");
        put(0, 10'h013, 4'b0110, 32'h00C4C5C6, 0, 1, "R2");
        put(0, 10'h022, 4'b1000, 32'hD7000000, 0, 1, "R2");
        put(0, 10'h030, 4'b1111, 32'h12345678, 1, 0, "R5");
        drain(0, 2);
        @(negedge clk);
        chk(!perm_req && !commit_valid, "R8", "idle after commit",
            {perm_req, commit_valid}, 0);

        // R3 set cap: four lines of set 1 fill the cap
        put(0, 10'h001, 4'b0001, 32'h11, 0, 1, "R3");
        put(0, 10'h005, 4'b0010, 32'h2200, 0, 1, "R3");
        put(0, 10'h009, 4'b0100, 32'h330000, 0, 1, "R3");
        put(0, 10'h00D, 4'b1000, 32'h44000000, 0, 1, "R3");
        put(0, 10'h002, 4'b1111, 32'h55555555, 0, 1, "R3");
        put(0, 10'h011, 4'b0001, 32'h66, 0, 0, "R3");
        drain(0, 1);
        put(0, 10'h011, 4'b0001, 32'h66, 0, 1, "R3");
        fence();
        drain(0, 0);

        // R4 full buffer: eight lines, two per set
        for (int i = 0; i < NE; i++)
            put(0, AW'(10'h020 + i), 4'b0001 << (i % 4), 32'h01010101 * (i + 1), 0, 1, "R4");
        put(0, 10'h023, 4'b0001, 32'h000000EE, 0, 1, "R4");
        put(0, 10'h028, 4'b0001, 32'h000000FF, 0, 0, "R4");
        drain(0, 0);
        put(0, 10'h028, 4'b0001, 32'h000000FF, 0, 1, "R4");
        fence();
        drain(0, 1);

        // R9 pending group while another drains
        put(0, 10'h041, 4'b0001, 32'h0A, 0, 1, "R9");
        put(0, 10'h040, 4'b0001, 32'h0B, 0, 1, "R9");
        fence();
        put(1, 10'h052, 4'b0011, 32'h0C0C, 0, 1, "R9");
        put(1, 10'h050, 4'b0001, 32'h0D, 0, 1, "R9");
        fence();
        put(1, 10'h060, 4'b0001, 32'h0E, 0, 0, "R9");
        put(1, 10'h050, 4'b0010, 32'h0F00, 0, 0, "R9");
        drain(0, 1);
        @(negedge clk);
        chk(perm_req && perm_line == 10'h050, "R9", "next group request",
            perm_line, 10'h050);
        drain(1, 0);

        // Sweep: pseudo-random stores, bench predicts every accept (R3, R4, R6, R10)
        seed = 32'h1234ABCD;
        for (int t = 0; t < 60; t++) begin
            int n = 1 + (t % 14);
            for (int s = 0; s < n; s++) begin
                logic [AW-1:0] ln;
                logic [NB-1:0] bm;
                bit ea;
                seed = seed * 32'd1103515245 + 32'd12345;
                ln = {4'b0, seed[21:16]};
                bm = (seed[11:8] == 4'b0) ? 4'b0001 : seed[11:8];
                ea = exp_accept(0, ln);
                put(0, ln, bm, seed ^ 32'h5A5AA5A5, 0, ea, "R10");
                if (!ea) begin
                    drain(0, t % 3);
                    put(0, ln, bm, seed ^ 32'h5A5AA5A5, 0, 1, "R3");
                end
            end
            fence();
            drain(0, t % 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule